// File: doc/BRIEF.md
# Calendar Shadow Read Unit

This block sits on the bus side of a real-time clock. It keeps shadow copies of the subsecond, time-of-day and date counters and returns them to register reads, so that software sees values that agree with each other even though the counters advance in a slower, unrelated clock domain. A divider in the RTC domain makes a refresh event every `RTC_DIV` RTC clock periods. A toggle synchronizer with edge detection carries that event into the bus domain, and the shadows are captured there.

A read-order lock keeps the three values consistent. Reading the subsecond register freezes the time and date shadows. Reading the time register freezes the date shadow. Reading the date register releases both. Each refresh sets a status flag that software can clear. The flag is also cleared on entry to initialization and after a subsecond shift, so software waits for fresh values. A bypass input makes reads return the live counters and holds the flag at zero. For single reads to be consistent, the bus clock must run at seven or more times the RTC clock. It must never run slower than the RTC clock.

Top module: `rtc_shadow_read`

## Requirements
- R1: A read strobe with select `rd_sel` (0 = subsecond, 1 = time, 2 = date, 3 = zero) puts the selected value, right-aligned and zero-extended, on `rd_data` one bus cycle after the strobe, and `rd_data` holds it until the next strobe. The value comes from the shadow when `bypass` is 0 and from the live counter when `bypass` is 1.
- R2: The RTC-domain divider makes one refresh every `RTC_DIV` RTC clock periods (default 2). Each refresh copies the live counters into the shadows that are not locked, and it sets `sync_flag` when `bypass` is 0.
- R3: A subsecond read blocks the time and date shadows from refreshing, starting in the cycle of the read.
- R4: A time read blocks the date shadow from refreshing, starting in the cycle of the read. The time shadow keeps refreshing.
- R5: A date read removes every lock, so later refreshes update the time and date shadows again.
- R6: The read order never locks the subsecond shadow. A refresh skips it only in a cycle where the subsecond register itself is being read.
- R7: While `bypass` is 1, `sync_flag` is 0 from the next cycle on and stays 0.
- R8: A `flag_clr` pulse clears `sync_flag`, and the next refresh sets it again. When both happen in the same cycle, the refresh wins.
- R9: `sync_flag` and `rd_data` reset to 0. An `init_enter` or `shift_done` pulse clears `sync_flag`, and in that cycle it takes priority over a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| rtc_clk | input | 1 | RTC clock |
| rtc_rst_n | input | 1 | Active-low reset, RTC domain |
| rd_stb | input | 1 | Calendar read strobe |
| rd_sel | input | 2 | Read select: 0 subsecond, 1 time, 2 date |
| bypass | input | 1 | Return live counters, hold flag at 0 |
| flag_clr | input | 1 | Software clear of the sync flag |
| init_enter | input | 1 | Pulse on entry to initialization mode |
| shift_done | input | 1 | Pulse after a subsecond shift |
| live_ss | input | SS_W | Live subsecond counter |
| live_time | input | TIME_W | Live time-of-day counter |
| live_date | input | DATE_W | Live date counter |
| rd_data | output | DATA_W | Read result |
| sync_flag | output | 1 | Shadow refresh flag |

## Verification
The bench builds the block with its defaults: `RTC_DIV` = 2, a two-stage synchronizer, registered read data, the lock enabled, a 16-bit subsecond field and 24-bit time and date fields. It runs the RTC clock at one eighth of the bus clock. That ratio keeps each refresh about sixteen bus cycles from the next. Because of this gap, a read sequence can fit between two refreshes, or it can be made to span several refreshes while the live counters roll over. This is what lets the bench show that a date read after a subsecond or time read returns the value frozen earlier.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;
   typedef enum logic [1:0] {
      SEL_SS   = 2'd0,
      SEL_TIME = 2'd1,
      SEL_DATE = 2'd2,
      SEL_NONE = 2'd3
   } cal_sel_e;
endpackage

// File: rtl/rtc_refresh_gen.sv
// RTC-domain divider: flips a level once every DIV rtc clocks.
module rtc_refresh_gen #(
   parameter int DIV = 2
) (
   input  logic rtc_clk,
   input  logic rtc_rst_n,
   output logic evt_tog
);
   localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

   if (DIV < 1) begin : g_bad_div
      $fatal(1, "rtc_refresh_gen: DIV must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge rtc_clk or negedge rtc_rst_n) begin
      if (!rtc_rst_n) begin
         cnt_q   <= '0;
         evt_tog <= 1'b0;
      end else if (cnt_q == LAST) begin
         cnt_q   <= '0;
         evt_tog <= ~evt_tog;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/rtc_event_sync.sv
// Bus-domain synchronizer for the refresh toggle, producing a one-cycle pulse.
module rtc_event_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tog_in,
   output logic pulse
);
   if (STAGES < 2) begin : g_bad_stages
      $fatal(1, "rtc_event_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], tog_in};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign pulse = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/rtc_shadow_bank.sv
// Shadow registers with the read-order lock.
module rtc_shadow_bank
   import rtc_shadow_pkg::*;
#(
   parameter int SS_W    = 16,
   parameter int TIME_W  = 24,
   parameter int DATE_W  = 24,
   parameter bit LOCK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              refresh,
   input  logic              rd_stb,
   input  logic [1:0]        rd_sel,
   input  logic [SS_W-1:0]   live_ss,
   input  logic [TIME_W-1:0] live_time,
   input  logic [DATE_W-1:0] live_date,
   output logic [SS_W-1:0]   sh_ss,
   output logic [TIME_W-1:0] sh_time,
   output logic [DATE_W-1:0] sh_date,
   output logic              lock_time,
   output logic              lock_date
);
   logic rd_ss, rd_tm, rd_dt;
   logic hold_time, hold_date;

   assign rd_ss = rd_stb && (rd_sel == SEL_SS);
   assign rd_tm = rd_stb && (rd_sel == SEL_TIME);
   assign rd_dt = rd_stb && (rd_sel == SEL_DATE);

   if (LOCK_EN) begin : g_lock
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lock_time <= 1'b0;
            lock_date <= 1'b0;
         end else if (rd_ss) begin
            lock_time <= 1'b1;
            lock_date <= 1'b1;
         end else if (rd_tm) begin
            lock_date <= 1'b1;
         end else if (rd_dt) begin
            lock_time <= 1'b0;
            lock_date <= 1'b0;
         end
      end
      assign hold_time = lock_time | rd_ss;
      assign hold_date = lock_date | rd_ss | rd_tm;
   end else begin : g_nolock
      assign lock_time = 1'b0;
      assign lock_date = 1'b0;
      assign hold_time = 1'b0;
      assign hold_date = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_ss   <= '0;
         sh_time <= '0;
         sh_date <= '0;
      end else if (refresh) begin
         if (!rd_ss)     sh_ss   <= live_ss;
         if (!hold_time) sh_time <= live_time;
         if (!hold_date) sh_date <= live_date;
      end
   end
endmodule

// File: rtl/rtc_sync_flag.sv
// Refresh status flag: clear sources ranked above set, set above software clear.
module rtc_sync_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic refresh,
   input  logic bypass,
   input  logic init_enter,
   input  logic shift_done,
   input  logic flag_clr,
   output logic flag
);
   logic force_low;
   assign force_low = bypass | init_enter | shift_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag <= 1'b0;
      else if (force_low)  flag <= 1'b0;
      else if (refresh)    flag <= 1'b1;
      else if (flag_clr)   flag <= 1'b0;
   end
endmodule

// File: rtl/rtc_shadow_read.sv
module rtc_shadow_read
   import rtc_shadow_pkg::*;
#(
   parameter int SS_W        = 16,
   parameter int TIME_W      = 24,
   parameter int DATE_W      = 24,
   parameter int DATA_W      = 32,
   parameter int RTC_DIV     = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit READ_REG    = 1'b1,
   parameter bit LOCK_EN     = 1'b1
) (
   input  logic              bus_clk,
   input  logic              bus_rst_n,
   input  logic              rtc_clk,
   input  logic              rtc_rst_n,
   input  logic              rd_stb,
   input  logic [1:0]        rd_sel,
   input  logic              bypass,
   input  logic              flag_clr,
   input  logic              init_enter,
   input  logic              shift_done,
   input  logic [SS_W-1:0]   live_ss,
   input  logic [TIME_W-1:0] live_time,
   input  logic [DATE_W-1:0] live_date,
   output logic [DATA_W-1:0] rd_data,
   output logic              sync_flag
);
   if (SS_W > DATA_W || TIME_W > DATA_W || DATE_W > DATA_W) begin : g_bad_width
      $fatal(1, "rtc_shadow_read: a calendar field is wider than DATA_W");
   end

   logic              evt_tog;
   logic              refresh_pulse;
   logic [SS_W-1:0]   sh_ss;
   logic [TIME_W-1:0] sh_time;
   logic [DATE_W-1:0] sh_date;
   logic              lock_time, lock_date;
   logic [DATA_W-1:0] sel_val;

   rtc_refresh_gen #(.DIV(RTC_DIV)) u_gen (
      .rtc_clk   (rtc_clk),
      .rtc_rst_n (rtc_rst_n),
      .evt_tog   (evt_tog)
   );

   rtc_event_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (bus_clk),
      .rst_n  (bus_rst_n),
      .tog_in (evt_tog),
      .pulse  (refresh_pulse)
   );

   rtc_shadow_bank #(
      .SS_W(SS_W), .TIME_W(TIME_W), .DATE_W(DATE_W), .LOCK_EN(LOCK_EN)
   ) u_bank (
      .clk       (bus_clk),
      .rst_n     (bus_rst_n),
      .refresh   (refresh_pulse),
      .rd_stb    (rd_stb),
      .rd_sel    (rd_sel),
      .live_ss   (live_ss),
      .live_time (live_time),
      .live_date (live_date),
      .sh_ss     (sh_ss),
      .sh_time   (sh_time),
      .sh_date   (sh_date),
      .lock_time (lock_time),
      .lock_date (lock_date)
   );

   rtc_sync_flag u_flag (
      .clk        (bus_clk),
      .rst_n      (bus_rst_n),
      .refresh    (refresh_pulse),
      .bypass     (bypass),
      .init_enter (init_enter),
      .shift_done (shift_done),
      .flag_clr   (flag_clr),
      .flag       (sync_flag)
   );

   always_comb begin
      sel_val = '0;
      case (rd_sel)
         SEL_SS:   sel_val = bypass ? DATA_W'(live_ss)   : DATA_W'(sh_ss);
         SEL_TIME: sel_val = bypass ? DATA_W'(live_time) : DATA_W'(sh_time);
         SEL_DATE: sel_val = bypass ? DATA_W'(live_date) : DATA_W'(sh_date);
         default:  sel_val = '0;
      endcase
   end

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge bus_clk or negedge bus_rst_n) begin
         if (!bus_rst_n)  rd_data <= '0;
         else if (rd_stb) rd_data <= sel_val;
      end
   end else begin : g_rd_comb
      assign rd_data = sel_val;
   end
endmodule

// File: rtl/rtc_shadow_chk.sv
module rtc_shadow_chk #(
   parameter int TIME_W = 24,
   parameter int DATE_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_stb,
   input logic [1:0]        rd_sel,
   input logic              bypass,
   input logic              init_enter,
   input logic              shift_done,
   input logic              refresh,
   input logic              lock_time,
   input logic              lock_date,
   input logic [TIME_W-1:0] sh_time,
   input logic [DATE_W-1:0] sh_date,
   input logic              sync_flag
);
   assert_ss_read_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && rd_sel == 2'd0) |=> (lock_time && lock_date));

   assert_time_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lock_time |=> $stable(sh_time));

   assert_time_read_locks_date_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && rd_sel == 2'd1) |=> lock_date);

   assert_date_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lock_date |=> $stable(sh_date));

   assert_date_read_unlocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && rd_sel == 2'd2) |=> (!lock_time && !lock_date));

   assert_refresh_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh && !bypass && !init_enter && !shift_done) |=> sync_flag);

   assert_bypass_flag_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |=> !sync_flag);

   assert_init_shift_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (init_enter || shift_done) |=> !sync_flag);
endmodule

bind rtc_shadow_read rtc_shadow_chk #(.TIME_W(TIME_W), .DATE_W(DATE_W)) u_chk (
   .clk        (bus_clk),
   .rst_n      (bus_rst_n),
   .rd_stb     (rd_stb),
   .rd_sel     (rd_sel),
   .bypass     (bypass),
   .init_enter (init_enter),
   .shift_done (shift_done),
   .refresh    (refresh_pulse),
   .lock_time  (lock_time),
   .lock_date  (lock_date),
   .sh_time    (sh_time),
   .sh_date    (sh_date),
   .sync_flag  (sync_flag)
);

// File: tb/tb_rtc_shadow_read.sv
module tb_rtc_shadow_read;
   localparam int BUS_PERIOD = 10;
   localparam int RTC_PERIOD = 8 * BUS_PERIOD;
   localparam int WATCHDOG   = 150000;

   logic        bus_clk = 1'b0, rtc_clk = 1'b0;
   logic        bus_rst_n = 1'b0, rtc_rst_n = 1'b0;
   logic        rd_stb = 1'b0;
   logic [1:0]  rd_sel = 2'd0;
   logic        bypass = 1'b0, flag_clr = 1'b0, init_enter = 1'b0, shift_done = 1'b0;
   logic [15:0] live_ss = '0;
   logic [23:0] live_time = '0, live_date = '0;
   logic [31:0] rd_data;
   logic        sync_flag;

   int checks = 0, failures = 0, cycles = 0;

   always #(BUS_PERIOD/2) bus_clk = ~bus_clk;
   always #(RTC_PERIOD/2) rtc_clk = ~rtc_clk;

   rtc_shadow_read dut (
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .rtc_clk(rtc_clk), .rtc_rst_n(rtc_rst_n),
      .rd_stb(rd_stb), .rd_sel(rd_sel), .bypass(bypass), .flag_clr(flag_clr),
      .init_enter(init_enter), .shift_done(shift_done),
      .live_ss(live_ss), .live_time(live_time), .live_date(live_date),
      .rd_data(rd_data), .sync_flag(sync_flag)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_live(input logic [15:0] s, input logic [23:0] t, input logic [23:0] d);
      @(negedge bus_clk);
      live_ss = s; live_time = t; live_date = d;
   endtask

   task automatic do_read(input logic [1:0] sel, output logic [31:0] val);
      @(negedge bus_clk);
      rd_stb = 1'b1; rd_sel = sel;
      @(negedge bus_clk);
      rd_stb = 1'b0;
      val = rd_data;
   endtask

   // Clear the flag, then wait for the next refresh to set it again.
   task automatic wait_refresh(input string tag);
      bit seen = 0;
      @(negedge bus_clk) flag_clr = 1'b1;
      @(negedge bus_clk) flag_clr = 1'b0;
      for (int i = 0; i < 100 && !seen; i++) begin
         if (sync_flag) seen = 1;
         else @(negedge bus_clk);
      end
      if (!seen) chk(tag, 32'(sync_flag), 32'd1);
   endtask

   task automatic t_reset;
      chk("R9 reset flag", 32'(sync_flag), 32'd0);
      chk("R9 reset rd_data", rd_data, 32'd0);
   endtask

   task automatic t_basic;
      logic [31:0] v;
      set_live(16'h1234, 24'h101010, 24'h240615);
      wait_refresh("R2 flag set by refresh");
      chk("R2 flag set", 32'(sync_flag), 32'd1);
      do_read(2'd0, v); chk("R1 shadow ss", v, 32'h1234);
      do_read(2'd1, v); chk("R1 shadow time", v, 32'h101010);
      do_read(2'd2, v); chk("R1 shadow date", v, 32'h240615);
      do_read(2'd3, v); chk("R1 select 3 reads zero", v, 32'd0);
      @(negedge bus_clk);
      chk("R1 rd_data holds", rd_data, 32'd0);
   endtask

   task automatic t_flag_clear;
      wait_refresh("R8 wait");
      @(negedge bus_clk) flag_clr = 1'b1;
      @(negedge bus_clk) flag_clr = 1'b0;
      chk("R8 software clear", 32'(sync_flag), 32'd0);
      wait_refresh("R8 set again after clear");
      chk("R8 set again", 32'(sync_flag), 32'd1);
   endtask

   task automatic t_ss_lock;
      logic [31:0] v;
      set_live(16'h00FF, 24'h235959, 24'h241231);
      wait_refresh("R3 wait A");
      do_read(2'd0, v); chk("R3 ss at lock", v, 32'h00FF);
      set_live(16'h0000, 24'h000000, 24'h250101);
      wait_refresh("R3 wait B1");
      wait_refresh("R3 wait B2");
      do_read(2'd1, v); chk("R3 time frozen by ss read", v, 32'h235959);
      do_read(2'd0, v); chk("R6 ss shadow keeps refreshing", v, 32'h0000);
      do_read(2'd2, v); chk("R3 date frozen across rollover", v, 32'h241231);
      wait_refresh("R5 wait after unlock");
      do_read(2'd2, v); chk("R5 date released", v, 32'h250101);
      do_read(2'd1, v); chk("R5 time released", v, 32'h000000);
      do_read(2'd2, v);
   endtask

   task automatic t_time_lock;
      logic [31:0] v;
      set_live(16'h0042, 24'h120000, 24'h250301);
      wait_refresh("R4 wait A");
      do_read(2'd1, v); chk("R4 time read", v, 32'h120000);
      set_live(16'h0043, 24'h120001, 24'h250302);
      wait_refresh("R4 wait B");
      do_read(2'd0, v); chk("R6 ss follows live", v, 32'h0043);
      do_read(2'd2, v); chk("R4 date frozen by time read", v, 32'h250301);
      wait_refresh("R4 wait C");
      do_read(2'd1, v); chk("R5 time refreshed after date read", v, 32'h120001);
      do_read(2'd2, v);
   endtask

   task automatic t_bypass;
      logic [31:0] v;
      bit stayed_low = 1;
      wait_refresh("R7 wait");
      @(negedge bus_clk) bypass = 1'b1;
      @(negedge bus_clk);
      chk("R7 flag forced low", 32'(sync_flag), 32'd0);
      for (int i = 0; i < 40; i++) begin
         @(negedge bus_clk);
         if (sync_flag) stayed_low = 0;
      end
      chk("R7 flag held low across refreshes", 32'(stayed_low), 32'd1);
      set_live(16'hBEEF, 24'h0A0B0C, 24'h260707);
      do_read(2'd0, v); chk("R1 bypass ss live", v, 32'hBEEF);
      do_read(2'd1, v); chk("R1 bypass time live", v, 32'h0A0B0C);
      do_read(2'd2, v); chk("R1 bypass date live", v, 32'h260707);
      @(negedge bus_clk) bypass = 1'b0;
   endtask

   task automatic t_init_shift;
      wait_refresh("R9 wait init");
      @(negedge bus_clk) init_enter = 1'b1;
      @(negedge bus_clk) init_enter = 1'b0;
      chk("R9 init clears flag", 32'(sync_flag), 32'd0);
      wait_refresh("R9 wait shift");
      @(negedge bus_clk) shift_done = 1'b1;
      @(negedge bus_clk) shift_done = 1'b0;
      chk("R9 shift clears flag", 32'(sync_flag), 32'd0);
   endtask

   always @(posedge bus_clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge bus_clk);
      t_reset();
      bus_rst_n = 1'b1;
      rtc_rst_n = 1'b1;
      t_basic();
      t_flag_clear();
      t_ss_lock();
      t_time_lock();
      t_bypass();
      t_init_shift();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule